// File: doc/BRIEF.md
# Dual-Bank Operand Memory with Auto-Stepping Pointers

This block is the data store of a small 16-bit signal-processing datapath. It contains two independent banks of 256 words by 16 bits. Each bank has its own file of four 8-bit address pointers. In one clock cycle the block can read one word from each bank, so a multiplier downstream receives both of its operands together.

Each bank has its own access port. The port carries an enable, a write flag, write data, a 2-bit pointer select and a 2-bit step mode. The selected pointer supplies the address for the access. The same pointer then holds, moves up by one or moves down by one, all within that cycle. A loop over a buffer therefore needs no separate address arithmetic.

A single pointer-load port can place any value into any pointer of either bank. Read data is registered, and both banks have the same one-cycle latency.

Top module: `dual_bank_dmem`

## Requirements
- R1: The two banks are separate 256-word by 16-bit stores: a write to one bank never changes the contents of the other bank at the same address.
- R2: Each bank has four pointers, chosen by its 2-bit select (0 to 3), and the access address is the current value of the chosen pointer.
- R3: The 2-bit step mode applies to the selected pointer after an enabled access: 00 leaves it unchanged, 01 adds one, 10 subtracts one, and 11 leaves it unchanged.
- R4: Pointers are 8 bits wide and wrap modulo 256: stepping up from 0xFF gives 0x00, and stepping down from 0x00 gives 0xFF.
- R5: An enabled read on both banks in the same cycle returns both words on the two read-data outputs at the next rising clock edge.
- R6: A write stores its data at the selected pointer's value before the step, and the step takes effect afterwards.
- R7: A pointer load writes the value into the addressed pointer at the next edge and wins over a step of that same pointer in that cycle. A step of a different pointer in the same cycle still happens. The access in the load cycle uses the old pointer value.
- R8: When a bank's enable is low, its pointers do not move. When a bank's enable is low or it performs a write, its read-data output keeps its previous value.
- R9: While reset is asserted, both read-data outputs are zero. After reset, every pointer of both banks is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Bank A access enable |
| a_wr | input | 1 | Bank A write (1) or read (0) |
| a_psel | input | 2 | Bank A pointer select |
| a_mode | input | 2 | Bank A step mode |
| a_wdata | input | 16 | Bank A write data |
| b_en | input | 1 | Bank B access enable |
| b_wr | input | 1 | Bank B write (1) or read (0) |
| b_psel | input | 2 | Bank B pointer select |
| b_mode | input | 2 | Bank B step mode |
| b_wdata | input | 16 | Bank B write data |
| pl_en | input | 1 | Pointer load enable |
| pl_bank | input | 1 | Pointer load target bank (0 = A, 1 = B) |
| pl_sel | input | 2 | Pointer load target pointer |
| pl_value | input | 8 | Pointer load value |
| a_rdata | output | 16 | Bank A registered read data |
| b_rdata | output | 16 | Bank B registered read data |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8-bit pointers and four pointers per bank. With these values, a preload of 256 writes through one incrementing pointer is short. That preload fills every word of both banks with a value that encodes its own address. It also brings the pointer back to zero through the upper wrap. Every later read therefore reveals the pointer value that produced it. Pointers loaded next to 0x00 and 0xFF bring both wrap directions within a few cycles.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_RSV  = 2'b11
  } step_mode_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/dmem_rst_sync.sv
module dmem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;

endmodule

// File: rtl/dmem_ptr_file.sv
module dmem_ptr_file
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_PTR = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_PTR)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            step_en,
  input  logic [SEL_W-1:0]                step_sel,
  input  logic [1:0]                      step_mode,
  input  logic                            ld_en,
  input  logic [SEL_W-1:0]                ld_sel,
  input  logic [ADDR_W-1:0]               ld_val,
  output logic [ADDR_W-1:0]               cur_ptr,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]  ptrs
);

  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_d;
  logic                           ptr_ce;
  step_mode_e                     mode_e;

  assign mode_e  = step_mode_e'(step_mode);
  assign cur_ptr = ptr_q[step_sel];
  assign ptrs    = ptr_q;
  assign ptr_ce  = step_en | ld_en;

  // Next-state: step first, then a load overrides the same slot.
  always_comb begin
    ptr_d = ptr_q;
    if (step_en) begin
      unique case (mode_e)
        STEP_INC: ptr_d[step_sel] = ptr_q[step_sel] + ADDR_W'(1);
        STEP_DEC: ptr_d[step_sel] = ptr_q[step_sel] - ADDR_W'(1);
        default:  ptr_d[step_sel] = ptr_q[step_sel];
      endcase
    end
    if (ld_en) begin
      ptr_d[ld_sel] = ld_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ce) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              wr_ce;
  logic              rd_ce;

  assign wr_ce = acc_en &  wr_en;
  assign rd_ce = acc_en & ~wr_en;

  always_ff @(posedge clk) begin
    if (wr_ce) begin
      mem_q[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_ce) begin
      rdata <= mem_q[addr];
    end
  end

endmodule

// File: rtl/dual_bank_dmem.sv
module dual_bank_dmem
  import dmem_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_PTR = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_PTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic [SEL_W-1:0]  a_psel,
  input  logic [1:0]        a_mode,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic [SEL_W-1:0]  b_psel,
  input  logic [1:0]        b_mode,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              pl_en,
  input  logic              pl_bank,
  input  logic [SEL_W-1:0]  pl_sel,
  input  logic [ADDR_W-1:0] pl_value,
  output logic [DATA_W-1:0] a_rdata,
  output logic [DATA_W-1:0] b_rdata
);

  logic                           rst_q_n;
  logic                           bk_en    [NUM_BANKS];
  logic                           bk_wr    [NUM_BANKS];
  logic [SEL_W-1:0]               bk_sel   [NUM_BANKS];
  logic [1:0]                     bk_mode  [NUM_BANKS];
  logic [DATA_W-1:0]              bk_wdata [NUM_BANKS];
  logic [DATA_W-1:0]              bk_rdata [NUM_BANKS];
  logic [ADDR_W-1:0]              bk_addr  [NUM_BANKS];
  logic [NUM_PTR-1:0][ADDR_W-1:0] bk_ptrs  [NUM_BANKS];
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_a;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_b;

  dmem_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign bk_en[0]    = a_en;
  assign bk_wr[0]    = a_wr;
  assign bk_sel[0]   = a_psel;
  assign bk_mode[0]  = a_mode;
  assign bk_wdata[0] = a_wdata;
  assign bk_en[1]    = b_en;
  assign bk_wr[1]    = b_wr;
  assign bk_sel[1]   = b_psel;
  assign bk_mode[1]  = b_mode;
  assign bk_wdata[1] = b_wdata;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic ld_hit;
    assign ld_hit = pl_en & (pl_bank == 1'(g));

    dmem_ptr_file #(
      .ADDR_W  (ADDR_W),
      .NUM_PTR (NUM_PTR)
    ) u_ptrs (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .step_en   (bk_en[g]),
      .step_sel  (bk_sel[g]),
      .step_mode (bk_mode[g]),
      .ld_en     (ld_hit),
      .ld_sel    (pl_sel),
      .ld_val    (pl_value),
      .cur_ptr   (bk_addr[g]),
      .ptrs      (bk_ptrs[g])
    );

    dmem_bank #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
    ) u_mem (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .acc_en (bk_en[g]),
      .wr_en  (bk_wr[g]),
      .addr   (bk_addr[g]),
      .wdata  (bk_wdata[g]),
      .rdata  (bk_rdata[g])
    );
  end

  assign a_rdata = bk_rdata[0];
  assign b_rdata = bk_rdata[1];
  assign ptr_a   = bk_ptrs[0];
  assign ptr_b   = bk_ptrs[1];

endmodule

// File: rtl/dual_bank_dmem_chk.sv
module dual_bank_dmem_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_PTR = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_PTR)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           a_en,
  input logic                           a_wr,
  input logic [SEL_W-1:0]               a_psel,
  input logic [1:0]                     a_mode,
  input logic                           b_en,
  input logic                           b_wr,
  input logic [SEL_W-1:0]               b_psel,
  input logic [1:0]                     b_mode,
  input logic                           pl_en,
  input logic                           pl_bank,
  input logic [SEL_W-1:0]               pl_sel,
  input logic [ADDR_W-1:0]              pl_value,
  input logic [DATA_W-1:0]              a_rdata,
  input logic [DATA_W-1:0]              b_rdata,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] pa,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] pb
);

  logic ld_a_same;
  logic ld_b_same;
  assign ld_a_same = pl_en & ~pl_bank & (pl_sel == a_psel);
  assign ld_b_same = pl_en &  pl_bank & (pl_sel == b_psel);

  a_r3_inc_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_mode == 2'b01 && !ld_a_same)
      |=> pa[$past(a_psel)] == $past(pa[a_psel]) + ADDR_W'(1));

  a_r3_dec_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_mode == 2'b10 && !ld_b_same)
      |=> pb[$past(b_psel)] == $past(pb[b_psel]) - ADDR_W'(1));

  a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && (a_mode == 2'b00 || a_mode == 2'b11) && !pl_en)
      |=> $stable(pa));

  a_r7_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_en && !pl_bank) |=> pa[$past(pl_sel)] == $past(pl_value));

  a_r7_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_en && pl_bank) |=> pb[$past(pl_sel)] == $past(pl_value));

  a_r8_idle_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_en || a_wr) |=> $stable(a_rdata));

  a_r8_idle_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_en || b_wr) |=> $stable(b_rdata));

  a_r8_noptr_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_en && !pl_en) |=> $stable(pb));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_zero: assert (a_rdata == '0 && b_rdata == '0);
    end
  end

endmodule

bind dual_bank_dmem dual_bank_dmem_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .NUM_PTR (NUM_PTR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .a_en     (a_en),
  .a_wr     (a_wr),
  .a_psel   (a_psel),
  .a_mode   (a_mode),
  .b_en     (b_en),
  .b_wr     (b_wr),
  .b_psel   (b_psel),
  .b_mode   (b_mode),
  .pl_en    (pl_en),
  .pl_bank  (pl_bank),
  .pl_sel   (pl_sel),
  .pl_value (pl_value),
  .a_rdata  (a_rdata),
  .b_rdata  (b_rdata),
  .pa       (ptr_a),
  .pb       (ptr_b)
);

// File: tb/dual_bank_dmem_tb.sv
module dual_bank_dmem_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_en, a_wr, b_en, b_wr;
  logic [1:0]  a_psel, a_mode, b_psel, b_mode;
  logic [15:0] a_wdata, b_wdata;
  logic        pl_en, pl_bank;
  logic [1:0]  pl_sel;
  logic [7:0]  pl_value;
  logic [15:0] a_rdata, b_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_bank_dmem u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_wr(a_wr), .a_psel(a_psel), .a_mode(a_mode), .a_wdata(a_wdata),
    .b_en(b_en), .b_wr(b_wr), .b_psel(b_psel), .b_mode(b_mode), .b_wdata(b_wdata),
    .pl_en(pl_en), .pl_bank(pl_bank), .pl_sel(pl_sel), .pl_value(pl_value),
    .a_rdata(a_rdata), .b_rdata(b_rdata)
  );

  // {a_psel, a_mode, b_psel, b_mode, expected a_rdata, expected b_rdata}
  localparam logic [39:0] VEC [10] = '{
    {2'd0, 2'b01, 2'd0, 2'b10, 16'hA010, 16'hB040},
    {2'd0, 2'b01, 2'd0, 2'b10, 16'hA011, 16'hB03F},
    {2'd2, 2'b01, 2'd3, 2'b01, 16'hA0FF, 16'hB0FE},
    {2'd2, 2'b00, 2'd3, 2'b01, 16'hA000, 16'hB0FF},
    {2'd3, 2'b10, 2'd3, 2'b00, 16'hA000, 16'hB000},
    {2'd3, 2'b11, 2'd1, 2'b11, 16'hA0FF, 16'hB001},
    {2'd3, 2'b00, 2'd1, 2'b10, 16'hA0FF, 16'hB001},
    {2'd1, 2'b10, 2'd1, 2'b00, 16'hA020, 16'hB000},
    {2'd1, 2'b01, 2'd2, 2'b01, 16'hA01F, 16'hB080},
    {2'd0, 2'b00, 2'd0, 2'b00, 16'hA012, 16'hB03E}
  };

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_en = 0; a_wr = 0; a_psel = 0; a_mode = 0; a_wdata = 0;
    b_en = 0; b_wr = 0; b_psel = 0; b_mode = 0; b_wdata = 0;
    pl_en = 0; pl_bank = 0; pl_sel = 0; pl_value = 0;
  endtask

  task automatic rd(logic [1:0] as, logic [1:0] am, logic [1:0] bs, logic [1:0] bm);
    idle();
    a_en = 1; a_psel = as; a_mode = am;
    b_en = 1; b_psel = bs; b_mode = bm;
  endtask

  task automatic load(logic bank, logic [1:0] sel, logic [7:0] val);
    idle();
    pl_en = 1; pl_bank = bank; pl_sel = sel; pl_value = val;
    cycle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset a_rdata", a_rdata, 16'h0000);
    check("R9 reset b_rdata", b_rdata, 16'h0000);
    rst_n = 1'b1;
    repeat (4) cycle();

    // Preload: 256 writes via pointer 0 stepping up in each bank.
    for (int i = 0; i < 256; i++) begin
      idle();
      a_en = 1; a_wr = 1; a_mode = 2'b01; a_wdata = 16'hA000 | 16'(i);
      b_en = 1; b_wr = 1; b_mode = 2'b01; b_wdata = 16'hB000 | 16'(i);
      cycle();
    end
    // R9: untouched pointers are 0; R4: pointer 0 wrapped back to 0.
    rd(2'd3, 2'b00, 2'd2, 2'b00); cycle();
    check("R9 ptrA3 zero", a_rdata, 16'hA000);
    check("R9 ptrB2 zero", b_rdata, 16'hB000);
    rd(2'd0, 2'b00, 2'd0, 2'b00); cycle();
    check("R4 ptrA0 wrapped", a_rdata, 16'hA000);
    check("R1 bank B distinct", b_rdata, 16'hB000);

    // R8: disabled ports hold the read data.
    idle(); a_psel = 2'd1; b_psel = 2'd1;
    cycle(); cycle();
    check("R8 idle a_rdata holds", a_rdata, 16'hA000);
    check("R8 idle b_rdata holds", b_rdata, 16'hB000);

    load(1'b0, 2'd0, 8'h10); load(1'b0, 2'd1, 8'h20);
    load(1'b0, 2'd2, 8'hFF); load(1'b0, 2'd3, 8'h00);
    load(1'b1, 2'd0, 8'h40); load(1'b1, 2'd1, 8'h01);
    load(1'b1, 2'd2, 8'h80); load(1'b1, 2'd3, 8'hFE);

    // Vector walk: R2/R3/R4/R5.
    for (int v = 0; v < 10; v++) begin
      rd(VEC[v][39:38], VEC[v][37:36], VEC[v][35:34], VEC[v][33:32]);
      cycle();
      check($sformatf("R5 R3 vec%0d bank A", v), a_rdata, VEC[v][31:16]);
      check($sformatf("R5 R3 vec%0d bank B", v), b_rdata, VEC[v][15:0]);
    end

    // R7: load beats a step of the same pointer; access uses old value.
    rd(2'd0, 2'b01, 2'd0, 2'b00);
    pl_en = 1; pl_bank = 0; pl_sel = 2'd0; pl_value = 8'h50;
    cycle();
    check("R7 access uses old ptr", a_rdata, 16'hA012);
    rd(2'd0, 2'b01, 2'd0, 2'b00);
    pl_en = 1; pl_bank = 0; pl_sel = 2'd2; pl_value = 8'h77;
    cycle();
    check("R7 load wins over step", a_rdata, 16'hA050);
    rd(2'd0, 2'b00, 2'd0, 2'b00); cycle();
    check("R7 other-ptr step applied", a_rdata, 16'hA051);
    rd(2'd2, 2'b00, 2'd0, 2'b00); cycle();
    check("R7 other-ptr load applied", a_rdata, 16'hA077);

    // R6/R8: write at A ptr1 (0x20), bank B reads in parallel.
    idle();
    a_en = 1; a_wr = 1; a_psel = 2'd1; a_mode = 2'b01; a_wdata = 16'h1234;
    b_en = 1; b_psel = 2'd2; b_mode = 2'b00;
    cycle();
    check("R8 write keeps a_rdata", a_rdata, 16'hA077);
    check("R5 bank B parallel read", b_rdata, 16'hB081);
    rd(2'd1, 2'b10, 2'd2, 2'b00); cycle();
    check("R6 step after write", a_rdata, 16'hA021);
    rd(2'd1, 2'b00, 2'd2, 2'b00); cycle();
    check("R6 write at pre-step addr", a_rdata, 16'h1234);
    load(1'b1, 2'd3, 8'h20);
    rd(2'd1, 2'b00, 2'd3, 2'b00); cycle();
    check("R1 bank B untouched at 0x20", b_rdata, 16'hB020);

    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule